// File: doc/BRIEF.md
# Packet Parser Dual ALU Stage

This block is the execution stage of a programmable packet-parser microengine. Each clock it accepts two decoded ALU instructions, lane 0 and lane 1, and applies them one after the other to the parser's architectural state. Lane 1 sees every write that lane 0 made in the same cycle. The whole result is registered at the end of the cycle.

The architectural state is held in three places. The first is a file of ten 16-bit general registers, ids 0 to 9, where id 9 is the next-protocol register. The second is a 12-bit error vector at id 10. The third is a 48-bit flag vector, addressed as 16-bit words through ids 12 to 15.

Arithmetic opcodes write a whole general register. Compare opcodes write one flag bit or one error bit, and also load a branch target into the next-protocol register. Two one-cycle pulses per lane report trouble. `invalid_op` marks an instruction that was refused. `range_err` marks a write that was dropped because its target lay outside the addressable state.

Top module: `pralu_pair`

## Requirements
- R1: While `rst_n` is low, all registers, flags and errors are cleared, and so are both pulse outputs.
- R2: The source operand is bits [start +: len] of the source word, shifted down to bit 0. A length of 0 gives 0. A length of 16 or more gives the whole word. Bits above bit 15 read as 0. Source ids map as follows: 0–9 read the general registers; 10 reads the error vector zero-extended; 12+w reads flag bits [16w +: 16], where flags at index 48 and above read as 0; id 11 reads 0.
- R3: Opcode 1 writes (src << shift) + imm to the destination register. Opcode 2 adds (src << shift) + imm to the destination register's current value. Results wrap modulo 2^16, and the shift is 0 to 15.
- R4: Opcode 6 writes (src << shift) XOR imm to the destination register.
- R5: Opcode 3 sets the addressed bit when src < imm. Opcode 4 sets it when src == imm. When the condition fails, the bit is left as it was. Both opcodes always load the branch field into register 9.
- R6: Opcode 5 writes the addressed bit to (src == imm), so it can clear a bit, and it loads the branch field into register 9.
- R7: A bit write to destination id 12–15 targets flag index (id − 12)·16 + dst_start. An index of 48 or more is dropped and raises `range_err` for that lane.
- R8: A bit write to id 10 targets error bit dst_start. A dst_start of 12 or more is dropped and raises `range_err`.
- R9: A bit write to ids 0–9 or 11 is dropped and raises `range_err`. So is an arithmetic write to ids 10–15. A compare whose condition fails under opcode 3 or 4 performs no bit write and raises nothing.
- R10: A nonzero shift-select field stops the instruction: no state changes, the next-protocol register is not loaded, and `invalid_op` is raised.
- R11: Opcode 0 changes nothing. Opcode 7 changes nothing and raises `invalid_op`.
- R12: Lane 1 executes after lane 0 in the same cycle. It reads lane 0's results, and it wins when both lanes write the same target.
- R13: State updates and pulses appear after the clock edge that samples the instructions. The pulses last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_opc | input | 2x3 | Opcode per lane |
| alu_src_id | input | 2x4 | Source register id per lane |
| alu_src_start | input | 2x4 | Source field lowest bit |
| alu_src_len | input | 2x5 | Source field length |
| alu_dst_id | input | 2x4 | Destination register id |
| alu_dst_start | input | 2x4 | Destination bit position for compares |
| alu_shift | input | 2x4 | Left shift applied to the source |
| alu_imm | input | 2x16 | Immediate operand |
| alu_branch | input | 2x16 | Value loaded into register 9 by compares |
| alu_xsel | input | 2x2 | Shift-select; nonzero refuses the instruction |
| gpr_o | output | 10x16 | General register file |
| flags_o | output | 48 | Flag vector |
| errs_o | output | 12 | Error vector |
| invalid_op | output | 2 | Per-lane refused-instruction pulse |
| range_err | output | 2 | Per-lane dropped-write pulse |

## Verification
The bench targets the following corner cases:

- **Flag index 48.** A design with an off-by-one range check would set a phantom flag instead of reporting the drop.
- **Error bit 12.** The same off-by-one fault applies here.
- **Clearing compare next to setting compares.** A design that treated the clearing compare like the setting ones would leave a stale flag.
- **Failing compare aimed at an unexpected id.** A careless decoder would raise `range_err` for a write that never happens.
- **Two lanes writing one target.** A lane-ordering fault shows up as lane 0's value surviving, or as lane 1 reading stale data.
- **Refused instruction.** A design that still executed it would alter a register or the next-protocol value.
- **Source field past bit 15.** A design that did not mask the field would leak high bits into the result.

// File: rtl/pralu_pkg.sv
package pralu_pkg;
    parameter int DATA_W   = 16;
    parameter int ID_W     = 4;
    parameter int POS_W    = 4;
    parameter int LEN_W    = 5;
    parameter int OPC_W    = 3;
    parameter int XSEL_W   = 2;
    parameter int NUM_ALU  = 2;
    parameter int NUM_GPR  = 10;
    parameter int NP_ID    = 9;
    parameter int ERR_ID   = 10;
    parameter int ERR_NUM  = 12;
    parameter int FLG_BASE = 12;
    parameter int FLG_NUM  = 48;

    localparam int FIDX_W   = ID_W + POS_W;
    localparam int FLG_WRDS = (1 << ID_W) - FLG_BASE;
    localparam int FLG_SPAN = FLG_WRDS * DATA_W;

    typedef enum logic [OPC_W-1:0] {
        OP_PARK    = 3'd0,
        OP_MOV_ADD = 3'd1,
        OP_ADD     = 3'd2,
        OP_ORLT    = 3'd3,
        OP_OREQ    = 3'd4,
        OP_SETEQ   = 3'd5,
        OP_MOV_XOR = 3'd6
    } opc_e;

    typedef struct packed {
        logic [OPC_W-1:0]  opc;
        logic [ID_W-1:0]   src_id;
        logic [POS_W-1:0]  src_start;
        logic [LEN_W-1:0]  src_len;
        logic [ID_W-1:0]   dst_id;
        logic [POS_W-1:0]  dst_start;
        logic [POS_W-1:0]  shift;
        logic [DATA_W-1:0] imm;
        logic [DATA_W-1:0] branch;
        logic [XSEL_W-1:0] xsel;
    } ins_t;

    typedef struct packed {
        logic [NUM_GPR-1:0][DATA_W-1:0] gpr;
        logic [FLG_NUM-1:0]             flg;
        logic [ERR_NUM-1:0]             err;
    } state_t;

    typedef struct packed {
        state_t             st;
        logic [NUM_ALU-1:0] inv;
        logic [NUM_ALU-1:0] rng;
    } reg_t;
endpackage

// File: rtl/pralu_srcsel.sv
module pralu_srcsel
    import pralu_pkg::*;
(
    input  state_t             st,
    input  logic [ID_W-1:0]    id,
    input  logic [POS_W-1:0]   start,
    input  logic [LEN_W-1:0]   len,
    output logic [DATA_W-1:0]  field
);
    logic [DATA_W-1:0]   word;
    logic [DATA_W-1:0]   mask;
    logic [FLG_SPAN-1:0] fpad;

    always_comb begin
        fpad = FLG_SPAN'(st.flg);
        word = '0;
        for (int g = 0; g < NUM_GPR; g++) begin
            if (id == ID_W'(g)) word = st.gpr[g];
        end
        if (id == ID_W'(ERR_ID)) word[ERR_NUM-1:0] = st.err;
        for (int w = 0; w < FLG_WRDS; w++) begin
            if (id == ID_W'(FLG_BASE + w)) word = fpad[w*DATA_W +: DATA_W];
        end
        if (len >= LEN_W'(DATA_W)) mask = '1;
        else                       mask = DATA_W'((32'd1 << len) - 32'd1);
        field = (word >> start) & mask;
    end
endmodule

// File: rtl/pralu_slice.sv
module pralu_slice
    import pralu_pkg::*;
(
    input  state_t st_i,
    input  ins_t   ins_i,
    output state_t st_o,
    output logic   inv_o,
    output logic   rng_o
);
    logic [DATA_W-1:0] src;
    logic [DATA_W-1:0] shv;
    logic [DATA_W-1:0] cur;
    logic [DATA_W-1:0] arith_val;
    logic              arith_we;
    logic              bit_we;
    logic              bit_val;
    logic [FIDX_W-1:0] fidx;

    pralu_srcsel u_src (
        .st    (st_i),
        .id    (ins_i.src_id),
        .start (ins_i.src_start),
        .len   (ins_i.src_len),
        .field (src)
    );

    always_comb begin
        st_o      = st_i;
        inv_o     = 1'b0;
        rng_o     = 1'b0;
        arith_we  = 1'b0;
        arith_val = '0;
        bit_we    = 1'b0;
        bit_val   = 1'b0;
        shv       = src << ins_i.shift;
        fidx      = {ins_i.dst_id - ID_W'(FLG_BASE), ins_i.dst_start};
        cur       = '0;
        for (int g = 0; g < NUM_GPR; g++) begin
            if (ins_i.dst_id == ID_W'(g)) cur = st_i.gpr[g];
        end

        if (ins_i.xsel != '0) begin
            inv_o = 1'b1;
        end else begin
            case (ins_i.opc)
                OP_PARK: ;
                OP_MOV_ADD: begin
                    arith_we  = 1'b1;
                    arith_val = shv + ins_i.imm;
                end
                OP_ADD: begin
                    arith_we  = 1'b1;
                    arith_val = cur + shv + ins_i.imm;
                end
                OP_MOV_XOR: begin
                    arith_we  = 1'b1;
                    arith_val = shv ^ ins_i.imm;
                end
                OP_ORLT: begin
                    bit_we  = (src < ins_i.imm);
                    bit_val = 1'b1;
                    st_o.gpr[NP_ID] = ins_i.branch;
                end
                OP_OREQ: begin
                    bit_we  = (src == ins_i.imm);
                    bit_val = 1'b1;
                    st_o.gpr[NP_ID] = ins_i.branch;
                end
                OP_SETEQ: begin
                    bit_we  = 1'b1;
                    bit_val = (src == ins_i.imm);
                    st_o.gpr[NP_ID] = ins_i.branch;
                end
                default: inv_o = 1'b1;
            endcase
        end

        if (arith_we) begin
            if (int'(ins_i.dst_id) < NUM_GPR) begin
                for (int g = 0; g < NUM_GPR; g++) begin
                    if (ins_i.dst_id == ID_W'(g)) st_o.gpr[g] = arith_val;
                end
            end else begin
                rng_o = 1'b1;
            end
        end

        if (bit_we) begin
            if (ins_i.dst_id == ID_W'(ERR_ID)) begin
                if (int'(ins_i.dst_start) < ERR_NUM) st_o.err[ins_i.dst_start] = bit_val;
                else                                 rng_o = 1'b1;
            end else if (int'(ins_i.dst_id) >= FLG_BASE) begin
                if (int'(fidx) < FLG_NUM) st_o.flg[fidx] = bit_val;
                else                      rng_o = 1'b1;
            end else begin
                rng_o = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pralu_pair.sv
module pralu_pair
    import pralu_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_ALU-1:0][OPC_W-1:0]    alu_opc,
    input  logic [NUM_ALU-1:0][ID_W-1:0]     alu_src_id,
    input  logic [NUM_ALU-1:0][POS_W-1:0]    alu_src_start,
    input  logic [NUM_ALU-1:0][LEN_W-1:0]    alu_src_len,
    input  logic [NUM_ALU-1:0][ID_W-1:0]     alu_dst_id,
    input  logic [NUM_ALU-1:0][POS_W-1:0]    alu_dst_start,
    input  logic [NUM_ALU-1:0][POS_W-1:0]    alu_shift,
    input  logic [NUM_ALU-1:0][DATA_W-1:0]   alu_imm,
    input  logic [NUM_ALU-1:0][DATA_W-1:0]   alu_branch,
    input  logic [NUM_ALU-1:0][XSEL_W-1:0]   alu_xsel,
    output logic [NUM_GPR-1:0][DATA_W-1:0]   gpr_o,
    output logic [FLG_NUM-1:0]               flags_o,
    output logic [ERR_NUM-1:0]               errs_o,
    output logic [NUM_ALU-1:0]               invalid_op,
    output logic [NUM_ALU-1:0]               range_err
);
    ins_t               ins   [NUM_ALU];
    state_t             stage [NUM_ALU+1];
    logic [NUM_ALU-1:0] inv_w;
    logic [NUM_ALU-1:0] rng_w;
    reg_t               q_d;
    reg_t               q_q;

    assign stage[0] = q_q.st;

    for (genvar k = 0; k < NUM_ALU; k++) begin : g_lane
        assign ins[k] = '{
            opc:       alu_opc[k],
            src_id:    alu_src_id[k],
            src_start: alu_src_start[k],
            src_len:   alu_src_len[k],
            dst_id:    alu_dst_id[k],
            dst_start: alu_dst_start[k],
            shift:     alu_shift[k],
            imm:       alu_imm[k],
            branch:    alu_branch[k],
            xsel:      alu_xsel[k]
        };

        pralu_slice u_slice (
            .st_i  (stage[k]),
            .ins_i (ins[k]),
            .st_o  (stage[k+1]),
            .inv_o (inv_w[k]),
            .rng_o (rng_w[k])
        );
    end

    always_comb begin
        q_d.st  = stage[NUM_ALU];
        q_d.inv = inv_w;
        q_d.rng = rng_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign gpr_o      = q_q.st.gpr;
    assign flags_o    = q_q.st.flg;
    assign errs_o     = q_q.st.err;
    assign invalid_op = q_q.inv;
    assign range_err  = q_q.rng;
endmodule

// File: rtl/pralu_pair_chk.sv
module pralu_pair_chk
    import pralu_pkg::*;
(
    input logic                           clk,
    input logic                           rst_n,
    input logic [OPC_W-1:0]               opc0,
    input logic [OPC_W-1:0]               opc1,
    input logic [XSEL_W-1:0]              xsel0,
    input logic [XSEL_W-1:0]              xsel1,
    input logic [ID_W-1:0]                dst_id0,
    input logic [ID_W-1:0]                dst_id1,
    input logic [POS_W-1:0]               dst_start0,
    input logic [DATA_W-1:0]              branch1,
    input logic [NUM_GPR-1:0][DATA_W-1:0] gpr,
    input logic [FLG_NUM-1:0]             flags,
    input logic [ERR_NUM-1:0]             errs,
    input logic [NUM_ALU-1:0]             inv,
    input logic [NUM_ALU-1:0]             rng
);
    logic [FIDX_W-1:0] fidx0;
    assign fidx0 = {dst_id0 - ID_W'(FLG_BASE), dst_start0};

    p_np_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (opc1 >= 3'd3 && opc1 <= 3'd5 && xsel1 == '0) |=> gpr[NP_ID] == $past(branch1));

    p_park_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (opc0 == 3'd0 && opc1 == 3'd0 && xsel0 == '0 && xsel1 == '0)
        |=> ($stable(gpr) && $stable(flags) && $stable(errs) && inv == '0 && rng == '0));

    p_bad_opc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (opc0 == 3'd7) |=> inv[0]);

    p_xsel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xsel0 != '0 && xsel1 != '0)
        |=> ($stable(gpr) && $stable(flags) && $stable(errs) && inv == 2'b11));

    p_arith_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((opc1 == 3'd1 || opc1 == 3'd2 || opc1 == 3'd6) && xsel1 == '0 && int'(dst_id1) < NUM_GPR)
        |=> (!rng[1] && !inv[1]));

    p_flag_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (opc0 == 3'd5 && xsel0 == '0 && int'(dst_id0) >= FLG_BASE && int'(fidx0) >= FLG_NUM)
        |=> rng[0]);
endmodule

bind pralu_pair pralu_pair_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .opc0       (alu_opc[0]),
    .opc1       (alu_opc[1]),
    .xsel0      (alu_xsel[0]),
    .xsel1      (alu_xsel[1]),
    .dst_id0    (alu_dst_id[0]),
    .dst_id1    (alu_dst_id[1]),
    .dst_start0 (alu_dst_start[0]),
    .branch1    (alu_branch[1]),
    .gpr        (gpr_o),
    .flags      (flags_o),
    .errs       (errs_o),
    .inv        (invalid_op),
    .rng        (range_err)
);

// File: tb/pralu_pair_bench.sv
`timescale 1ns/1ps
module pralu_pair_bench;
    import pralu_pkg::*;

    logic                            clk = 1'b0;
    logic                            rst_n = 1'b0;
    logic [NUM_ALU-1:0][OPC_W-1:0]   alu_opc;
    logic [NUM_ALU-1:0][ID_W-1:0]    alu_src_id;
    logic [NUM_ALU-1:0][POS_W-1:0]   alu_src_start;
    logic [NUM_ALU-1:0][LEN_W-1:0]   alu_src_len;
    logic [NUM_ALU-1:0][ID_W-1:0]    alu_dst_id;
    logic [NUM_ALU-1:0][POS_W-1:0]   alu_dst_start;
    logic [NUM_ALU-1:0][POS_W-1:0]   alu_shift;
    logic [NUM_ALU-1:0][DATA_W-1:0]  alu_imm;
    logic [NUM_ALU-1:0][DATA_W-1:0]  alu_branch;
    logic [NUM_ALU-1:0][XSEL_W-1:0]  alu_xsel;
    logic [NUM_GPR-1:0][DATA_W-1:0]  gpr_o;
    logic [FLG_NUM-1:0]              flags_o;
    logic [ERR_NUM-1:0]              errs_o;
    logic [NUM_ALU-1:0]              invalid_op;
    logic [NUM_ALU-1:0]              range_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pralu_pair u_pralu_pair (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic park_all();
        alu_opc = '0; alu_src_id = '0; alu_src_start = '0; alu_src_len = '0;
        alu_dst_id = '0; alu_dst_start = '0; alu_shift = '0; alu_imm = '0;
        alu_branch = '0; alu_xsel = '0;
    endtask

    task automatic set(input int k, input int opc, input int sid, input int sst, input int slen,
                       input int did, input int dst, input int sh, input int imm, input int br,
                       input int xs);
        alu_opc[k]       = OPC_W'(opc);
        alu_src_id[k]    = ID_W'(sid);
        alu_src_start[k] = POS_W'(sst);
        alu_src_len[k]   = LEN_W'(slen);
        alu_dst_id[k]    = ID_W'(did);
        alu_dst_start[k] = POS_W'(dst);
        alu_shift[k]     = POS_W'(sh);
        alu_imm[k]       = DATA_W'(imm);
        alu_branch[k]    = DATA_W'(br);
        alu_xsel[k]      = XSEL_W'(xs);
    endtask

    // Apply current instructions at the next edge; sample well after it.
    task automatic step();
        @(posedge clk);
        #5;
        park_all();
    endtask

    task automatic t_reset();
        park_all();
        set(0, 1, 0, 0, 0, 0, 0, 0, 16'h1111, 0, 0);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        chk("R1 gpr", 64'(|gpr_o), 0);
        chk("R1 flags", 64'(flags_o), 0);
        chk("R1 errs", 64'(errs_o), 0);
        chk("R1 pulses", 64'({invalid_op, range_err}), 0);
        park_all();
        rst_n = 1'b1;
    endtask

    task automatic t_arith();
        set(0, 1, 0, 0, 0, 0, 0, 0, 16'hA5C3, 0, 0);
        set(1, 1, 0, 0, 0, 1, 0, 0, 16'h00F0, 0, 0);
        step();
        chk("R3 load r0", 64'(gpr_o[0]), 64'hA5C3);
        chk("R3 load r1", 64'(gpr_o[1]), 64'h00F0);
        set(0, 1, 0, 4, 8, 2, 0, 0, 0, 0, 0);
        set(1, 1, 0, 12, 8, 3, 0, 0, 0, 0, 0);
        step();
        chk("R2 field mid", 64'(gpr_o[2]), 64'h005C);
        chk("R2 field past top", 64'(gpr_o[3]), 64'h000A);
        set(0, 1, 0, 0, 16, 4, 0, 4, 0, 0, 0);
        set(1, 1, 0, 0, 31, 5, 0, 0, 0, 0, 0);
        step();
        chk("R3 shift wrap", 64'(gpr_o[4]), 64'h5C30);
        chk("R2 long len", 64'(gpr_o[5]), 64'hA5C3);
        set(0, 2, 1, 0, 16, 1, 0, 8, 16'h0010, 0, 0);
        set(1, 2, 0, 0, 16, 0, 0, 0, 1, 0, 0);
        step();
        chk("R3 add", 64'(gpr_o[1]), 64'hF100);
        chk("R3 add wrap", 64'(gpr_o[0]), 64'h4B87);
        set(0, 6, 1, 8, 8, 5, 0, 4, 16'hFFFF, 0, 0);
        step();
        chk("R4 xor", 64'(gpr_o[5]), 64'hF0EF);
    endtask

    task automatic t_chain();
        set(0, 1, 0, 0, 0, 6, 0, 0, 16'h1234, 0, 0);
        set(1, 1, 6, 0, 16, 7, 0, 0, 1, 0, 0);
        step();
        chk("R12 lane1 reads lane0", 64'(gpr_o[7]), 64'h1235);
        chk("R12 lane0 write", 64'(gpr_o[6]), 64'h1234);
        set(0, 1, 0, 0, 0, 8, 0, 0, 1, 0, 0);
        set(1, 1, 0, 0, 0, 8, 0, 0, 2, 0, 0);
        step();
        chk("R12 lane1 wins", 64'(gpr_o[8]), 2);
    endtask

    task automatic t_compare();
        set(0, 3, 6, 0, 16, 12, 3, 0, 16'h2000, 16'h0042, 0);
        set(1, 4, 6, 0, 16, 13, 0, 0, 16'h1235, 16'h0077, 0);
        step();
        chk("R5 orlt sets flag3", 64'(flags_o), 64'h8);
        chk("R5 np loaded", 64'(gpr_o[9]), 64'h0077);
        chk("R9 failed oreq no pulse", 64'(range_err), 0);
        set(0, 3, 6, 0, 16, 12, 3, 0, 16'h1000, 16'h0005, 0);
        step();
        chk("R5 orlt false keeps bit", 64'(flags_o), 64'h8);
        chk("R5 np on false", 64'(gpr_o[9]), 64'h0005);
        set(0, 5, 6, 0, 16, 12, 3, 0, 0, 16'h0011, 0);
        set(1, 5, 6, 0, 16, 14, 15, 0, 16'h1234, 16'h0022, 0);
        step();
        chk("R6 seteq clear and R7 index 47", 64'(flags_o), 64'h8000_0000_0000);
        chk("R6 np", 64'(gpr_o[9]), 64'h0022);
    endtask

    task automatic t_ranges();
        set(0, 5, 6, 0, 16, 15, 0, 0, 16'h1234, 16'h0033, 0);
        set(1, 4, 6, 0, 16, 10, 11, 0, 16'h1234, 16'h0044, 0);
        step();
        chk("R7 flag 48 dropped pulse", 64'(range_err), 64'b01);
        chk("R7 flags unchanged", 64'(flags_o), 64'h8000_0000_0000);
        chk("R8 error bit 11", 64'(errs_o), 64'h800);
        chk("R5 np lane1", 64'(gpr_o[9]), 64'h0044);
        step();
        chk("R13 pulse one cycle", 64'({invalid_op, range_err}), 0);
        set(0, 4, 6, 0, 16, 10, 12, 0, 16'h1234, 16'h0055, 0);
        set(1, 5, 6, 0, 16, 11, 0, 0, 16'h1234, 16'h0066, 0);
        step();
        chk("R8 R9 drops", 64'(range_err), 64'b11);
        chk("R8 errs unchanged", 64'(errs_o), 64'h800);
        chk("R9 np still loaded", 64'(gpr_o[9]), 64'h0066);
        set(0, 3, 6, 0, 16, 11, 0, 0, 0, 16'h0077, 0);
        set(1, 1, 0, 0, 0, 10, 0, 0, 16'hFFFF, 0, 0);
        step();
        chk("R9 arith to id10 dropped", 64'(range_err), 64'b10);
        chk("R9 errs after arith", 64'(errs_o), 64'h800);
        chk("R9 np", 64'(gpr_o[9]), 64'h0077);
    endtask

    task automatic t_invalid();
        set(0, 7, 0, 0, 0, 0, 0, 0, 16'hBEEF, 0, 0);
        set(1, 1, 0, 0, 0, 0, 0, 0, 16'hDEAD, 0, 1);
        step();
        chk("R11 R10 invalid pulses", 64'(invalid_op), 64'b11);
        chk("R10 r0 untouched", 64'(gpr_o[0]), 64'h4B87);
        chk("R11 no range", 64'(range_err), 0);
        set(0, 5, 6, 0, 16, 12, 0, 0, 16'h1234, 16'h0099, 2);
        step();
        chk("R10 np not loaded", 64'(gpr_o[9]), 64'h0077);
        chk("R10 flags unchanged", 64'(flags_o), 64'h8000_0000_0000);
        chk("R10 lane0 pulse", 64'(invalid_op), 64'b01);
        step();
        chk("R11 park no change", 64'(gpr_o[9]), 64'h0077);
    endtask

    task automatic t_special_src();
        set(0, 1, 14, 0, 16, 0, 0, 0, 0, 0, 0);
        set(1, 1, 10, 0, 16, 1, 0, 0, 0, 0, 0);
        step();
        chk("R2 flag word source", 64'(gpr_o[0]), 64'h8000);
        chk("R2 error source", 64'(gpr_o[1]), 64'h0800);
        set(0, 1, 15, 0, 16, 2, 0, 0, 0, 0, 0);
        set(1, 1, 11, 0, 16, 3, 0, 0, 7, 0, 0);
        step();
        chk("R2 flags past 48 read zero", 64'(gpr_o[2]), 0);
        chk("R2 id11 reads zero", 64'(gpr_o[3]), 7);
    endtask

    initial begin
        t_reset();
        t_arith();
        t_chain();
        t_compare();
        t_ranges();
        t_invalid();
        t_special_src();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R13 actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule